// File: doc/BRIEF.md
# Key-Return Wake and Interrupt Detector

This block watches four active-low key inputs and turns a key press into one of two actions: an interrupt request, or a request for a system reset. It brings each key pin into the clock domain through a synchronizer. It then ANDs the four levels together and detects a falling edge on the combined level. Because the keys are combined this way, a press counts only while every other key is released. A 2-bit source-select register on a small register bus arms the detector. A request flag holds the interrupt until software clears it with a write.

The CPU operating mode (run, halt, stop) and an external reset-enable pin together choose the action. In run and halt, a press sets the request flag. In stop with the reset-enable pin high, a press produces a one-cycle system reset pulse and leaves the flag alone. In stop with the pin low, a press sets the flag and also pulses a wake output. If the source is armed while a key is already held down, the flag is set even without a new edge. Software must therefore disarm, clear and re-arm whenever it reprograms the register.

Top module: `key_wake_det`

## Requirements
- R1: After reset the source-select register reads 00, `irq_o` is 0, and `wake_o` and `sys_rst_o` are 0.
- R2: While the source-select register holds 00, 10 or 11, a key press causes no request, no wake and no reset. A written value reads back unchanged at register address 0.
- R3: With source select 01, a falling edge on any single key, while all keys were high, sets `irq_o`. `keys_ni` bit value 0 means pressed.
- R4: While any key is held low (pressed), pressing another key does not set `irq_o`.
- R5: With `cpu_mode_i` equal to 00 (run), 01 (halt) or 11 (treated as run), a detected press sets `irq_o`. In these modes it never pulses `sys_rst_o` or `wake_o`, whatever the level of `rst_en_i`.
- R6: With `cpu_mode_i` equal to 10 (stop) and `rst_en_i` high, a detected press gives exactly one single-cycle pulse on `sys_rst_o` and leaves `irq_o` unchanged.
- R7: With `cpu_mode_i` equal to 10 (stop) and `rst_en_i` low, a detected press sets `irq_o` and gives one single-cycle pulse on `wake_o`.
- R8: A write that changes the source select from a value other than 01 to 01, while any key is held low, sets `irq_o`. The same write with all keys high leaves `irq_o` at 0.
- R9: `irq_o` stays set until a write to address 1 with `wdata_i` bit 0 set. A write to address 1 with bit 0 clear leaves it set.
- R10: When a detected press and a clear write fall on the same clock edge, `irq_o` ends up set.
- R11: `irq_o` rises on the third rising clock edge that follows the change of `keys_ni`. It is still 0 after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| keys_ni | input | 4 | Key pins, 0 = pressed, asynchronous |
| cpu_mode_i | input | 2 | 00 run, 01 halt, 10 stop, 11 treated as run |
| rst_en_i | input | 1 | In stop mode, 1 selects system reset instead of wake |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = source select, 1 = request flag |
| wdata_i | input | 2 | Write data; at address 1, bit 0 = 1 clears the flag |
| rdata_o | output | 2 | Read data for `addr_i` (address 1 returns {0, flag}) |
| irq_o | output | 1 | Interrupt request flag |
| wake_o | output | 1 | One-cycle pulse leaving stop without reset |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach is a press that lands on exactly the same edge as a clear write. It can only be produced by counting the synchronizer and edge-register delay from the key pin. The bench drives the key on a falling clock edge and waits two rising edges. It then raises the clear write so that the write meets the third edge, where the set takes effect. The spurious request on arming is reached by holding a key low with the source disarmed, clearing the flag, and only then writing 01.

// File: rtl/kw_pkg.sv
package kw_pkg;
  typedef enum logic [1:0] {
    CPU_RUN  = 2'b00,
    CPU_HALT = 2'b01,
    CPU_STOP = 2'b10,
    CPU_RSV  = 2'b11
  } cpu_mode_e;

  localparam int unsigned SEL_W    = 2;
  localparam logic [SEL_W-1:0] SEL_KEYS = 2'b01;
  localparam logic ADDR_SEL  = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;
endpackage

// File: rtl/kw_sync.sv
module kw_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    // idle level of a released key is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/kw_edge.sv
module kw_edge #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] keys_s_i,
  output logic             all_hi_o,
  output logic             fall_o
);
  logic all_hi_q;

  assign all_hi_o = &keys_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) all_hi_q <= 1'b1;
    else         all_hi_q <= all_hi_o;
  end

  assign fall_o = all_hi_q & ~all_hi_o;
endmodule

// File: rtl/kw_ctrl.sv
module kw_ctrl
  import kw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             all_hi_i,
  input  logic             fall_i,
  input  logic [1:0]       cpu_mode_i,
  input  logic             rst_en_i,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [SEL_W-1:0] wdata_i,
  output logic [SEL_W-1:0] rdata_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             irq_o,
  output logic             wake_o,
  output logic             sys_rst_o
);
  logic [SEL_W-1:0] sel_q;
  logic src_en, src_en_q, evt, in_stop, flag_q, set_flag, clr_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sel_q <= '0;
    else if (wr_i && addr_i == ADDR_SEL) sel_q <= wdata_i;
  end

  // 10 and 11 are kept but act as no source
  assign src_en = (sel_q == SEL_KEYS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_en_q <= 1'b0;
    else         src_en_q <= src_en;
  end

  // arming while a key is held low counts as an event
  assign evt      = src_en & (fall_i | (~src_en_q & ~all_hi_i));
  assign in_stop  = (cpu_mode_e'(cpu_mode_i) == CPU_STOP);
  assign set_flag = evt & ~(in_stop & rst_en_i);
  assign clr_flag = wr_i & (addr_i == ADDR_FLAG) & wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= 1'b0;
      wake_o    <= 1'b0;
      sys_rst_o <= 1'b0;
    end else begin
      if (set_flag)      flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
      wake_o    <= evt & in_stop & ~rst_en_i;
      sys_rst_o <= evt & in_stop & rst_en_i;
    end
  end

  assign irq_o   = flag_q;
  assign sel_o   = sel_q;
  assign rdata_o = (addr_i == ADDR_FLAG) ? {{(SEL_W-1){1'b0}}, flag_q} : sel_q;
endmodule

// File: rtl/key_wake_det.sv
module key_wake_det
  import kw_pkg::*;
#(
  parameter int unsigned NUM_KEYS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] keys_ni,
  input  logic [1:0]          cpu_mode_i,
  input  logic                rst_en_i,
  input  logic                wr_i,
  input  logic                addr_i,
  input  logic [SEL_W-1:0]    wdata_i,
  output logic [SEL_W-1:0]    rdata_o,
  output logic                irq_o,
  output logic                wake_o,
  output logic                sys_rst_o
);
  logic [NUM_KEYS-1:0] keys_s;
  logic                all_hi, fall;
  logic [SEL_W-1:0]    sel_w;

  kw_sync #(.WIDTH(NUM_KEYS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(keys_ni), .q_o(keys_s)
  );

  kw_edge #(.WIDTH(NUM_KEYS)) u_edge (
    .clk_i, .rst_ni, .keys_s_i(keys_s), .all_hi_o(all_hi), .fall_o(fall)
  );

  kw_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .all_hi_i(all_hi), .fall_i(fall),
    .cpu_mode_i, .rst_en_i,
    .wr_i, .addr_i, .wdata_i,
    .rdata_o, .sel_o(sel_w),
    .irq_o, .wake_o, .sys_rst_o
  );
endmodule

// File: rtl/key_wake_det_chk.sv
module key_wake_det_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] cpu_mode_i,
  input logic       rst_en_i,
  input logic       wr_i,
  input logic       addr_i,
  input logic [1:0] wdata_i,
  input logic [1:0] sel_w,
  input logic       irq_o,
  input logic       wake_o,
  input logic       sys_rst_o
);
  // R6
  rst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);
  // R7
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  // R6
  rst_only_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> $past(cpu_mode_i == 2'b10 && rst_en_i));
  // R5
  wake_only_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(cpu_mode_i == 2'b10 && !rst_en_i));
  // R9
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_i && addr_i && wdata_i[0]));
  // R2
  flag_needs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(sel_w == 2'b01));
  // R6
  rst_keeps_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> !$rose(irq_o));
endmodule

bind key_wake_det key_wake_det_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_mode_i(cpu_mode_i), .rst_en_i(rst_en_i),
  .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .sel_w(sel_w),
  .irq_o(irq_o), .wake_o(wake_o), .sys_rst_o(sys_rst_o)
);

// File: tb/key_wake_det_bench.sv
module key_wake_det_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] keys_ni = 4'hF;
  logic [1:0] cpu_mode_i = 2'b00;
  logic       rst_en_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [1:0] wdata_i = 2'b00;
  logic [1:0] rdata_o;
  logic       irq_o, wake_o, sys_rst_o;

  int tests = 0, fails = 0;
  int rst_cnt = 0, wake_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic  irq;
    int    rsts;
    int    wakes;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  key_wake_det u_key_wake_det (
    .clk_i(clk), .rst_ni, .keys_ni, .cpu_mode_i, .rst_en_i,
    .wr_i, .addr_i, .wdata_i, .rdata_o, .irq_o, .wake_o, .sys_rst_o
  );

  // monitor: counts pulses, pops and compares expected items
  always @(negedge clk) begin
    if (rst_ni) begin
      if (sys_rst_o) rst_cnt++;
      if (wake_o)    wake_cnt++;
    end
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      tests++;
      if (irq_o !== e.irq || rst_cnt != e.rsts || wake_cnt != e.wakes) begin
        fails++;
        $display("FAIL %s: irq=%b rst=%0d wake=%0d expected irq=%b rst=%0d wake=%0d",
                 e.tag, irq_o, rst_cnt, wake_cnt, e.irq, e.rsts, e.wakes);
      end
    end
  end

  // driver: push after a rising edge, monitor checks at the next falling edge
  task automatic expect_st(input logic irq, input int rsts, input int wakes, input string tag);
    exp_t e;
    @(posedge clk); #1;
    e.irq = irq; e.rsts = rsts; e.wakes = wakes; e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic a, input logic [1:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0; addr_i = 1'b0; wdata_i = 2'b00;
  endtask

  task automatic check_rd(input logic a, input logic [1:0] exp, input string tag);
    @(negedge clk);
    addr_i = a; #1;
    tests++;
    if (rdata_o !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%b expected %b", tag, rdata_o, exp);
    end
    addr_i = 1'b0;
  endtask

  task automatic press(input logic [3:0] k);
    @(negedge clk); keys_ni = k; idle(5);
  endtask

  task automatic clear_flag();
    bus_wr(1'b1, 2'b01); idle(1);
  endtask

  initial begin
    idle(3); rst_ni = 1'b1;
    // R1
    expect_st(1'b0, 0, 0, "R1 reset outputs");
    check_rd(1'b0, 2'b00, "R1 select reset value");

    // R2: no source
    press(4'hE); expect_st(1'b0, 0, 0, "R2 sel 00 ignores press");
    press(4'hF);
    bus_wr(1'b0, 2'b10); check_rd(1'b0, 2'b10, "R2 readback 10");
    press(4'hB); expect_st(1'b0, 0, 0, "R2 sel 10 ignores press");
    press(4'hF);
    bus_wr(1'b0, 2'b11); check_rd(1'b0, 2'b11, "R2 readback 11");
    press(4'h7); expect_st(1'b0, 0, 0, "R2 sel 11 ignores press");
    press(4'hF);

    // R8 negative: arm with keys released
    bus_wr(1'b0, 2'b01); idle(2);
    expect_st(1'b0, 0, 0, "R8 arm with keys high");

    // R3 / R11: exact latency
    @(negedge clk); keys_ni = 4'hB;
    @(posedge clk);
    expect_st(1'b0, 0, 0, "R11 still low after second edge");
    expect_st(1'b1, 0, 0, "R11 R3 set on third edge");
    check_rd(1'b1, 2'b01, "R3 flag readback");
    press(4'hF);

    // R9
    bus_wr(1'b1, 2'b00); idle(1);
    expect_st(1'b1, 0, 0, "R9 write bit0=0 keeps flag");
    clear_flag();
    expect_st(1'b0, 0, 0, "R9 clear write");

    // R4
    press(4'hE); clear_flag();
    press(4'hC); expect_st(1'b0, 0, 0, "R4 second key while first held");
    press(4'hF); expect_st(1'b0, 0, 0, "R4 release is not an edge");

    // R5
    rst_en_i = 1'b1; cpu_mode_i = 2'b00;
    press(4'hD); expect_st(1'b1, 0, 0, "R5 run with rst_en high");
    press(4'hF); clear_flag();
    cpu_mode_i = 2'b01;
    press(4'h7); expect_st(1'b1, 0, 0, "R5 halt with rst_en high");
    press(4'hF); clear_flag();
    cpu_mode_i = 2'b11;
    press(4'hE); expect_st(1'b1, 0, 0, "R5 mode 11 as run");
    press(4'hF); clear_flag();

    // R6
    cpu_mode_i = 2'b10; rst_en_i = 1'b1;
    press(4'hE); expect_st(1'b0, 1, 0, "R6 stop reset pulse");
    press(4'hF);

    // R7
    rst_en_i = 1'b0;
    press(4'hB); expect_st(1'b1, 1, 1, "R7 stop wake pulse");
    press(4'hF); clear_flag();
    cpu_mode_i = 2'b00;

    // R8 positive: arm while key held
    bus_wr(1'b0, 2'b00); press(4'hE); clear_flag();
    expect_st(1'b0, 1, 1, "R8 disarmed with key held");
    bus_wr(1'b0, 2'b01); idle(2);
    expect_st(1'b1, 1, 1, "R8 arm with key held sets flag");
    bus_wr(1'b0, 2'b00); clear_flag(); press(4'hF);
    bus_wr(1'b0, 2'b01); idle(2);
    expect_st(1'b0, 1, 1, "R8 safe re-arm sequence");

    // R10: set and clear on the same edge, flag already set
    press(4'hE); press(4'hF);
    @(negedge clk); keys_ni = 4'hD;
    @(posedge clk);
    @(posedge clk); #1;
    wr_i = 1'b1; addr_i = 1'b1; wdata_i = 2'b01;
    @(posedge clk); #1;
    wr_i = 1'b0; addr_i = 1'b0; wdata_i = 2'b00;
    expect_st(1'b1, 1, 1, "R10 set wins over clear");
    clear_flag();
    expect_st(1'b0, 1, 1, "R10 later clear works");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule